// File: doc/BRIEF.md
# Burst Address Generator

This block produces the address that one port presents to a memory array in each clock cycle. It chooses between an address supplied from outside and an internal counter. Three active-low controls steer it: a counter clear, an address strobe and a count enable. Their priority is fixed, with clear first, then strobe, then count enable. When none of them is asserted, the counter holds its value.

The access address is the value the counter will hold after the coming rising edge, presented during the same cycle. A cleared cycle therefore already accesses address 0, and a strobed cycle already accesses the external address, so no cycle is lost on a clear or a load. A counting cycle accesses the next sequential address.

The counter is as wide as the array address and wraps from the all-ones address back to 0. Chip enables and the read/write direction are not inputs, so counting continues whether or not the port is selected.

Top module: `burst_addr_gen`

## Requirements
- R1: When cntRstN is low, accessAddr is 0 in that cycle and cntVal is 0 after the rising edge, whatever adsN, cntEnN and extAddr are.
- R2: When adsN is low and cntRstN is high, accessAddr equals extAddr in that cycle, and the counter takes extAddr at the rising edge.
- R3: When cntEnN is low and adsN and cntRstN are both high, accessAddr is cntVal plus one, and cntVal advances by one at the rising edge.
- R4: cntEnN has no effect in any cycle where adsN or cntRstN is low. The result of such a cycle is the same as with cntEnN high.
- R5: When cntRstN, adsN and cntEnN are all high, cntVal keeps its value, accessAddr equals cntVal, and extAddr is ignored.
- R6: Counting from the all-ones address (2^ADDR_W - 1) gives address 0. Both accessAddr and cntVal wrap.
- R7: In every cycle after the first clear or load, the value of cntVal after the rising edge equals the value accessAddr had before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock; all state changes on its rising edge |
| extAddr | input | ADDR_W | Address supplied from outside |
| adsN | input | 1 | Address strobe, active low: load extAddr |
| cntEnN | input | 1 | Count enable, active low: advance the counter |
| cntRstN | input | 1 | Counter clear, active low: force address 0 |
| accessAddr | output | ADDR_W | Address used for the array access in this cycle |
| cntVal | output | ADDR_W | Present registered counter value |

## Verification
The hardest case to reach from the ports is a wrap that arrives through counting alone, because the counter normally sits far from the all-ones address. The bench loads an address a few words below the top and then lets the counter run across the boundary. It also combines the clear and the strobe with a low count enable, so that the priority ordering is visible at the ports. A pseudo-random phase driven by an LFSR follows, checking accessAddr and cntVal every cycle against a reference model of the requirements.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

  // Decoded action for one cycle; at most one bit is set.
  typedef struct packed {
    logic clear;
    logic load;
    logic step;
  } ctrlStrobes_t;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_STEP  = 2'd1,
    ACT_LOAD  = 2'd2,
    ACT_CLEAR = 2'd3
  } addrAction_e;

endpackage

// File: rtl/burst_addr_ctrl.sv
module burst_addr_ctrl
  import burst_addr_pkg::*;
(
  input  logic         adsN,
  input  logic         cntEnN,
  input  logic         cntRstN,
  output ctrlStrobes_t strobes
);

  addrAction_e action;

  // Fixed priority: clear, then load, then step, else hold.
  always_comb begin
    if (!cntRstN)     action = ACT_CLEAR;
    else if (!adsN)   action = ACT_LOAD;
    else if (!cntEnN) action = ACT_STEP;
    else              action = ACT_HOLD;
  end

  always_comb begin
    strobes       = '0;
    strobes.clear = (action == ACT_CLEAR);
    strobes.load  = (action == ACT_LOAD);
    strobes.step  = (action == ACT_STEP);
  end

endmodule

// File: rtl/burst_addr_dp.sv
module burst_addr_dp
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] extAddr,
  output logic [ADDR_W-1:0] nextAddr,
  output logic [ADDR_W-1:0] cntQ
);

  localparam logic [ADDR_W-1:0] ONE  = {{(ADDR_W-1){1'b0}}, 1'b1};
  localparam logic [ADDR_W-1:0] ZERO = '0;

  logic [ADDR_W-1:0] incAddr;

  // Modulo-2^ADDR_W increment gives the wrap for free.
  assign incAddr = cntQ + ONE;

  always_comb begin
    if (strobes.clear)     nextAddr = ZERO;
    else if (strobes.load) nextAddr = extAddr;
    else if (strobes.step) nextAddr = incAddr;
    else                   nextAddr = cntQ;
  end

  always_ff @(posedge clk) begin
    cntQ <= nextAddr;
  end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] extAddr,
  input  logic              adsN,
  input  logic              cntEnN,
  input  logic              cntRstN,
  output logic [ADDR_W-1:0] accessAddr,
  output logic [ADDR_W-1:0] cntVal
);

  ctrlStrobes_t      strobes;
  logic [ADDR_W-1:0] nextAddr;
  logic [ADDR_W-1:0] cntQ;

  burst_addr_ctrl u_ctrl (
    .adsN    (adsN),
    .cntEnN  (cntEnN),
    .cntRstN (cntRstN),
    .strobes (strobes)
  );

  burst_addr_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .strobes  (strobes),
    .extAddr  (extAddr),
    .nextAddr (nextAddr),
    .cntQ     (cntQ)
  );

  // Bypass: the access uses the value the counter is about to take.
  assign accessAddr = nextAddr;
  assign cntVal     = cntQ;

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic [ADDR_W-1:0] extAddr,
  input logic              adsN,
  input logic              cntEnN,
  input logic              cntRstN,
  input logic [ADDR_W-1:0] accessAddr,
  input logic [ADDR_W-1:0] cntVal,
  input ctrlStrobes_t      strobes
);

  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  // Counter content is defined only after the first clear or load.
  logic primed = 1'b0;
  always_ff @(posedge clk) begin
    if (!cntRstN || !adsN) primed <= 1'b1;
  end

  a_r1_clear_zero: assert property (@(posedge clk)
    !cntRstN |-> (accessAddr == '0));

  a_r1_clear_cnt: assert property (@(posedge clk)
    !cntRstN |=> (cntVal == '0));

  a_r2_load: assert property (@(posedge clk)
    (cntRstN && !adsN) |=> (cntVal == $past(extAddr)));

  a_r3_step: assert property (@(posedge clk) disable iff (!primed)
    (cntRstN && adsN && !cntEnN) |=> (cntVal == $past(cntVal) + ONE));

  // R4: only one action may be decoded per cycle
  a_r4_one_action: assert property (@(posedge clk)
    $onehot0({strobes.clear, strobes.load, strobes.step}));

  a_r5_hold: assert property (@(posedge clk) disable iff (!primed)
    (cntRstN && adsN && cntEnN) |=> $stable(cntVal));

  a_r7_bypass: assert property (@(posedge clk) disable iff (!primed)
    1'b1 |=> (cntVal == $past(accessAddr)));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .extAddr    (extAddr),
  .adsN       (adsN),
  .cntEnN     (cntEnN),
  .cntRstN    (cntRstN),
  .accessAddr (accessAddr),
  .cntVal     (cntVal),
  .strobes    (strobes)
);

// File: tb/sim_burst_addr_gen.sv
module sim_burst_addr_gen;

  localparam int AW = 8;
  localparam int NVEC = 14;
  localparam int WORD = 3 + 3 * AW;

  logic          clk = 1'b0;
  logic [AW-1:0] extAddr = '0;
  logic          adsN = 1'b1;
  logic          cntEnN = 1'b1;
  logic          cntRstN = 1'b1;
  logic [AW-1:0] accessAddr;
  logic [AW-1:0] cntVal;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 1'b0;

  always #2.5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) u0 (
    .clk        (clk),
    .extAddr    (extAddr),
    .adsN       (adsN),
    .cntEnN     (cntEnN),
    .cntRstN    (cntRstN),
    .accessAddr (accessAddr),
    .cntVal     (cntVal)
  );

  // {cntRstN, adsN, cntEnN, extAddr, expected accessAddr, expected cntVal}
  localparam logic [WORD-1:0] VEC [NVEC] = '{
    {3'b011, 8'h55, 8'h00, 8'h00},  // R1 clear
    {3'b101, 8'h10, 8'h10, 8'h10},  // R2 load
    {3'b110, 8'h99, 8'h11, 8'h11},  // R3 step, ext ignored
    {3'b110, 8'h00, 8'h12, 8'h12},  // R3 step
    {3'b111, 8'h77, 8'h12, 8'h12},  // R5 hold
    {3'b100, 8'h40, 8'h40, 8'h40},  // R4 load beats enable
    {3'b110, 8'h00, 8'h41, 8'h41},  // R3
    {3'b000, 8'h80, 8'h00, 8'h00},  // R4 clear beats both
    {3'b110, 8'h33, 8'h01, 8'h01},  // R3 from zero
    {3'b011, 8'hAA, 8'h00, 8'h00},  // R1
    {3'b101, 8'hFE, 8'hFE, 8'hFE},  // R2
    {3'b110, 8'h00, 8'hFF, 8'hFF},  // R3
    {3'b110, 8'h00, 8'h00, 8'h00},  // R6 wrap
    {3'b111, 8'h5A, 8'h00, 8'h00}   // R5 hold at zero
  };

  task automatic check(input string req, input logic [AW-1:0] got,
                       input logic [AW-1:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic logic [AW-1:0] refNext(input logic [AW-1:0] cur,
      input logic rst, input logic ads, input logic en, input logic [AW-1:0] ext);
    if (!rst)      return '0;
    else if (!ads) return ext;
    else if (!en)  return cur + 8'd1;
    else           return cur;
  endfunction

  // One cycle: drive at negedge, check access address, then counter after edge.
  task automatic stepRef(input logic rst, input logic ads, input logic en,
                         input logic [AW-1:0] ext, inout logic [AW-1:0] model,
                         input string req);
    logic [AW-1:0] nxt;
    @(negedge clk);
    cntRstN = rst; adsN = ads; cntEnN = en; extAddr = ext;
    nxt = refNext(model, rst, ads, en, ext);
    #1 check({req, " access"}, accessAddr, nxt);
    @(posedge clk);
    #1 check({req, " counter"}, cntVal, nxt);
    model = nxt;
  endtask

  initial begin : stim
    logic [AW-1:0] model;
    logic [15:0]   lfsr;
    model = '0;
    // R1: reset state reached through the clear input
    stepRef(1'b0, 1'b1, 1'b1, 8'h3C, model, "R1 reset state");

    for (int i = 0; i < NVEC; i++) begin
      logic [WORD-1:0] v;
      v = VEC[i];
      @(negedge clk);
      {cntRstN, adsN, cntEnN, extAddr} = v[WORD-1 -: 3+AW];
      #1 check($sformatf("R7 vec%0d access", i), accessAddr, v[2*AW-1 -: AW]);
      @(posedge clk);
      #1 check($sformatf("R7 vec%0d counter", i), cntVal, v[AW-1:0]);
    end
    model = 8'h00;

    // R6: run a long burst across the top address
    stepRef(1'b1, 1'b0, 1'b1, 8'hF0, model, "R2 burst start");
    for (int i = 0; i < 40; i++)
      stepRef(1'b1, 1'b1, 1'b0, 8'h00, model, "R6 burst wrap");
    check("R6 wrapped end", cntVal, 8'h18);

    // R4: enable low with strobe or clear low behaves as enable high
    stepRef(1'b1, 1'b0, 1'b0, 8'hC3, model, "R4 load with enable");
    stepRef(1'b0, 1'b0, 1'b0, 8'hC3, model, "R4 clear with enable");
    stepRef(1'b0, 1'b1, 1'b0, 8'h11, model, "R4 clear only with enable");
    // R5: hold many cycles with changing external address
    for (int i = 0; i < 8; i++)
      stepRef(1'b1, 1'b1, 1'b1, 8'(i * 37), model, "R5 hold ignores ext");

    // R7: pseudo-random mix against the reference model
    lfsr = 16'hACE1;
    for (int i = 0; i < 500; i++) begin
      logic rst, ads, en;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rst = (lfsr[3:0] != 4'h0);
      ads = (lfsr[6:4] != 3'h0);
      en  = lfsr[7] & lfsr[8];
      stepRef(rst, ads, en, lfsr[15:8], model, "R7 random");
    end

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin : watchdog
    #(5ns * 200000);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule